// File: doc/BRIEF.md
# Fast-Read Serial Flash Slave Front End

This block is the serial-peripheral slave side of a NOR-style flash that answers the high-speed read command. The block runs on a system clock that is much faster than the serial clock. It samples chip select, serial clock and data in through synchronizers and acts on the detected serial-clock edges. The serial link uses mode 0: the serial clock idles low, data in is sampled on the rising edge and data out changes on the falling edge.

After chip select goes low, the block gathers an 8-bit opcode. If the opcode is the fast-read code and the write engine is idle, the block takes in a 24-bit address and then one dummy byte. After that it streams array bytes MSB first on the data output, reading one incrementing address per byte until chip select is released. The array sits outside the block behind a synchronous read port with one clock of latency.

The control is a state machine with six states:
- **IDLE**: not selected.
- **OPCODE**: collecting the opcode.
- **ADDR**: collecting the address.
- **DUMMY**: skipping the dummy byte.
- **DATA**: streaming bytes.
- **IGNORE**: the rest of a rejected command.

The transitions are:
- IDLE to OPCODE when select is seen.
- OPCODE to ADDR on the eighth bit if the opcode is accepted, or OPCODE to IGNORE if it is not.
- ADDR to DUMMY on the 24th address bit. This transition also issues the first array read.
- DUMMY to DATA on the eighth dummy bit.
- DATA and IGNORE hold their state.
- Any state goes to IDLE as soon as select is released.

Top module: `spi_fastread_slave`

## Requirements
- R1: After reset, `miso_oe` and `rd_en` are both 0.
- R2: The opcode, the address and the dummy byte are each sampled MSB first on rising serial-clock edges. The opcode is 0x0B, followed by a 24-bit address and then 8 dummy bits. `miso_oe` stays 0 for all 40 of these bits.
- R3: During the data phase `miso_oe` is 1. Each data bit appears on `miso` after a falling serial-clock edge, MSB first. Bit 7 of the first byte follows the falling edge that comes after the last dummy bit.
- R4: Successive bytes of one command come from successive array addresses. The first byte comes from the received address.
- R5: Only the low log2(MEM_BYTES) bits of the 24-bit address select the byte. MEM_BYTES is a power of two of at least 256. The upper address bits have no effect.
- R6: After byte MEM_BYTES-1 the stream continues from address 0 without a break.
- R7: If `busy` is 1 when the eighth opcode bit is sampled, the command is ignored. `miso_oe` stays 0 until deselect and no array read is issued.
- R8: Any opcode other than 0x0B is ignored in the same way as in R7.
- R9: Releasing chip select during the opcode, address or dummy bits discards the partial bits. The next select starts a fresh opcode.
- R10: Releasing chip select during the data phase ends the stream and drops `miso_oe`. The next command is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` |
| busy | input | 1 | Erase or program in progress |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | AW | Array read address (AW = log2(MEM_BYTES)) |
| rd_data | input | 8 | Array read data, valid one clock after `rd_en` |

## Verification
Each serial pin change is seen after two synchronizer clocks. Because of that, a new `miso` bit is due on the third system clock after the falling edge of `sck`, and `miso_oe` follows a change of `cs_n` after the same three clocks. The bench changes the pins on falling system-clock edges. It compares `miso` and `miso_oe` against its reference on every clock of the window from four to seven clocks after each serial falling edge, after the result has settled. The deselect checks are made five clocks after `cs_n` rises. The array reads are counted over each whole command to confirm the R7 and R8 rejection.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam logic [7:0] OP_FAST_READ = 8'h0B;
    localparam int         CMD_BITS     = 8;
    localparam int         ADDR_BITS    = 24;
    localparam int         DUMMY_BITS   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } fr_state_e;

endpackage

// File: rtl/fr_pin_sync.sv
module fr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] mosi_q;
    logic              sck_prev;

    // first stage samples the pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q[0]   <= 1'b1;
            sck_q[0]  <= 1'b0;
            mosi_q[0] <= 1'b0;
        end else begin
            cs_q[0]   <= cs_n;
            sck_q[0]  <= sck;
            mosi_q[0] <= mosi;
        end
    end

    // remaining stages of the chain
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cs_q[g]   <= 1'b1;
                sck_q[g]  <= 1'b0;
                mosi_q[g] <= 1'b0;
            end else begin
                cs_q[g]   <= cs_q[g-1];
                sck_q[g]  <= sck_q[g-1];
                mosi_q[g] <= mosi_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_q[LAST];
        end
    end

    assign sel      = ~cs_q[LAST];
    assign sck_rise = sck_q[LAST] & ~sck_prev;
    assign sck_fall = ~sck_q[LAST] & sck_prev;
    assign mosi_s   = mosi_q[LAST];

endmodule

// File: rtl/fr_addr_gen.sv
module fr_addr_gen #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr
);
    // AW-bit arithmetic makes the wrap to zero implicit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_en   <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_en <= load | step;
            if (load) begin
                rd_addr <= load_addr;
            end else if (step) begin
                rd_addr <= rd_addr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fr_tx_shifter.sv
module fr_tx_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       shift,
    input  logic       fill,
    input  logic [7:0] fill_data,
    output logic       dout,
    output logic       byte_start
);
    logic [7:0] nxt_byte;
    logic [7:0] cur_byte;
    logic [2:0] bit_idx;

    assign byte_start = active & shift & (bit_idx == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_byte <= '0;
            cur_byte <= '0;
            bit_idx  <= '0;
            dout     <= 1'b0;
        end else begin
            if (fill) begin
                nxt_byte <= fill_data;
            end
            if (!active) begin
                cur_byte <= '0;
                bit_idx  <= '0;
                dout     <= 1'b0;
            end else if (shift) begin
                if (bit_idx == 3'd0) begin
                    dout     <= nxt_byte[7];
                    cur_byte <= {nxt_byte[6:0], 1'b0};
                end else begin
                    dout     <= cur_byte[7];
                    cur_byte <= {cur_byte[6:0], 1'b0};
                end
                bit_idx <= bit_idx + 3'd1;
            end
        end
    end

endmodule

// File: rtl/spi_fastread_slave.sv
module spi_fastread_slave
    import fr_pkg::*;
#(
    parameter  int MEM_BYTES   = 4096,
    parameter  int SYNC_STAGES = 2,
    localparam int AW          = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    output logic          miso,
    output logic          miso_oe,
    input  logic          busy,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);
    localparam int SR_W = (AW - 1 > 7) ? AW - 1 : 7;

    fr_state_e       state_q, state_d;
    logic            sel, sck_rise, sck_fall, mosi_s;
    logic [4:0]      bit_cnt;
    logic [SR_W-1:0] in_sr;
    logic            rd_vld;
    logic            opcode_done, addr_done, dummy_done;
    logic            accept;
    logic [7:0]      cmd_word;
    logic [AW-1:0]   start_addr;
    logic            tx_active, tx_dout, byte_start;

    fr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .mosi     (mosi),
        .sel      (sel),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s)
    );

    // word completed by the bit being sampled now
    assign cmd_word    = {in_sr[6:0], mosi_s};
    assign start_addr  = {in_sr[AW-2:0], mosi_s};
    assign accept      = (cmd_word == OP_FAST_READ) && !busy;
    assign opcode_done = (state_q == ST_OPCODE) && sck_rise && (bit_cnt == 5'(CMD_BITS - 1));
    assign addr_done   = (state_q == ST_ADDR)   && sck_rise && (bit_cnt == 5'(ADDR_BITS - 1));
    assign dummy_done  = (state_q == ST_DUMMY)  && sck_rise && (bit_cnt == 5'(DUMMY_BITS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (opcode_done) state_d = accept ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (addr_done)   state_d = ST_DUMMY;
                ST_DUMMY:  if (dummy_done)  state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit counting and serial capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            in_sr   <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (state_d != state_q) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 5'd1;
            end
            if (sck_rise) begin
                in_sr <= {in_sr[SR_W-2:0], mosi_s};
            end
        end
    end

    // outputs
    always_comb begin
        tx_active = (state_q == ST_DATA);
        miso_oe   = tx_active;
        miso      = tx_dout;
    end

    fr_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_done),
        .load_addr (start_addr),
        .step      (byte_start),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr)
    );

    fr_tx_shifter u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (tx_active),
        .shift      (sck_fall),
        .fill       (rd_vld),
        .fill_data  (rd_data),
        .dout       (tx_dout),
        .byte_start (byte_start)
    );

endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          miso,
    input logic          miso_oe,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          in_data,
    input logic          in_ignore,
    input logic          sck_fall
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!miso_oe && !rd_en));

    a_r3_bit_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && (miso != $past(miso))) |-> $past(sck_fall));

    // R4 and R6: each read in the stream is one past the last, modulo the array
    a_r4_sequential_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(in_data)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    a_r7_no_fetch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        in_ignore |-> !rd_en);

    a_r10_oe_off_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 3) && $past(cs_n, 2) && $past(cs_n) && cs_n) |-> !miso_oe);

endmodule

bind spi_fastread_slave fr_checker #(.AW(AW)) u_fr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .in_data   (state_q == ST_DATA),
    .in_ignore (state_q == ST_IGNORE),
    .sck_fall  (sck_fall)
);

// File: tb/test_spi_fastread_slave.sv
module test_spi_fastread_slave;
    localparam int MEM_BYTES = 4096;
    localparam int AW        = 12;
    localparam int HALF      = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          mosi = 1'b0;
    logic          busy = 1'b0;
    logic          miso, miso_oe, rd_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;

    int    checks = 0;
    int    errors = 0;
    int    rd_count = 0;
    logic  cmp_en = 1'b0;
    logic  exp_oe = 1'b0;
    logic  exp_bit = 1'b0;
    string cur_req = "";
    logic  finished = 1'b0;

    always #10 clk = ~clk;

    spi_fastread_slave #(.MEM_BYTES(MEM_BYTES)) i_spi_fastread_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe),
        .busy    (busy),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(((a * 37) + 11) ^ (a >> 4));
    endfunction

    // array model: one clock read latency
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= pat(int'(rd_addr));
            rd_count = rd_count + 1;
        end
    end

    // reference compare on every clock of the settled window
    always @(negedge clk) begin
        if (cmp_en) begin
            checks = checks + 1;
            if (miso_oe !== exp_oe || (exp_oe && miso !== exp_bit)) begin
                errors = errors + 1;
                $display("FAIL %s: oe=%b miso=%b expected oe=%b miso=%b",
                         cur_req, miso_oe, miso, exp_oe, exp_bit);
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(logic ok, string req, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic spi_bit(logic din, logic eoe, logic ebit);
        sck  = 1'b0;
        mosi = din;
        wait_clk(4);
        exp_oe  = eoe;
        exp_bit = ebit;
        cmp_en  = 1'b1;
        wait_clk(4);
        cmp_en = 1'b0;
        sck    = 1'b1;
        wait_clk(HALF);
    endtask

    // cut < 0: run all bits; else stop after cut bits (header + data)
    task automatic run_cmd(logic [7:0] op, logic [23:0] addr, int nbytes,
                           logic busy_v, int cut, string req);
        logic [39:0] hdr;
        logic [7:0]  e;
        logic        serve;
        int          total;
        int          rd_before;
        hdr       = {op, addr, 8'h00};
        serve     = (op == 8'h0B) && !busy_v;
        total     = (cut < 0) ? 40 + 8 * nbytes : cut;
        cur_req   = req;
        busy      = busy_v;
        rd_before = rd_count;
        cs_n      = 1'b0;
        wait_clk(4);
        for (int i = 0; i < total; i++) begin
            if (i < 40) begin
                spi_bit(hdr[39 - i], 1'b0, 1'b0);
            end else begin
                e = serve ? pat(int'(({20'h0, addr[AW-1:0]} + 32'((i - 40) / 8)) % MEM_BYTES)) : 8'h00;
                spi_bit(1'b0, serve, e[7 - ((i - 40) % 8)]);
            end
        end
        cs_n = 1'b1;
        wait_clk(5);
        chk(miso_oe == 1'b0, {req, " oe low after deselect"}, int'(miso_oe), 0);
        sck = 1'b0;
        wait_clk(4);
        busy = 1'b0;
        if (!serve) begin
            chk(rd_count == rd_before, {req, " no array reads"}, rd_count - rd_before, 0);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        chk(miso_oe == 1'b0, "R1 oe after reset", int'(miso_oe), 0);
        chk(rd_en == 1'b0, "R1 rd_en after reset", int'(rd_en), 0);

        run_cmd(8'h0B, 24'h000010, 3, 1'b0, -1, "R2 R3 R4 basic read");
        run_cmd(8'h0B, 24'h0000A7, 2, 1'b0, -1, "R3 R4 odd start");
        run_cmd(8'h0B, 24'h000FFE, 4, 1'b0, -1, "R6 wrap to zero");
        run_cmd(8'h0B, 24'hABC123, 2, 1'b0, -1, "R5 upper bits ignored");
        run_cmd(8'h0B, 24'h000040, 2, 1'b1, -1, "R7 busy rejects");
        run_cmd(8'h03, 24'h000040, 2, 1'b0, -1, "R8 other opcode");
        run_cmd(8'h0B, 24'h000300, 0, 1'b0, 3,  "R9 cut in opcode");
        run_cmd(8'h0B, 24'h000300, 0, 1'b0, 20, "R9 cut in address");
        run_cmd(8'h0B, 24'h000300, 0, 1'b0, 36, "R9 cut in dummy");
        run_cmd(8'h0B, 24'h000200, 2, 1'b0, -1, "R9 fresh after cuts");
        run_cmd(8'h0B, 24'h000080, 2, 1'b0, 52, "R10 cut in data");
        run_cmd(8'h0B, 24'h000055, 1, 1'b0, -1, "R10 next command served");
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule